// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register side of a serial port. A bus master reads and writes 32-bit words through a single-cycle register port that covers a 4 KB window. Received characters arrive as whole bytes on a valid/ready stream and collect in a receive queue of up to sixteen entries. A word written to the data register leaves at once as a one-cycle byte strobe toward the serialiser. Turning the queue off in the line-control register shrinks it to a single holding slot.

Two interrupt sources, one for receive and one for transmit, are latched in a raw status word. That word is gated by a mask register, and the result drives a single interrupt line. The receive source fires when the queue fill reaches a programmable threshold. It drops when a data read takes the fill one below that threshold. The queue is read one byte per bus read. Eight fixed identification bytes occupy the last eight words of the window. Divisor, line-control, control and threshold registers are stored and read back for the serialiser next door.

Top module: `uart_fe`

## Requirements
- R1: With line-control bit 4 set, the queue takes up to 16 bytes in arrival order. `rx_ready` is high exactly while fewer than 16 are held, and a byte offered while it is low is dropped.
- R2: With line-control bit 4 clear, the queue has room for one byte: `rx_ready` falls once one byte is held.
- R3: A read of word offset 0 returns the oldest held byte in bits 7:0 (upper bits zero) and removes it. On an empty queue it returns 0 and the fill stays 0.
- R4: Word offset 6 reads the flags. Bit 7 (transmit empty) is always 1 and bit 5 (transmit full) is always 0. Bit 6 (receive full) is 1 while the fill is at or above capacity. Bit 4 (receive empty) is 1 while the fill is zero. All other bits are 0.
- R5: The receive threshold is ((word 13 >> 1) & 0x1C) with the queue on, and 1 with it off. Raw status bit 4 is set by an accepted byte that brings the fill equal to the threshold.
- R6: Raw status bit 4 is cleared by a data read after which the fill equals the threshold minus one.
- R7: A write to word offset 0 drives `tx_valid` high in that same cycle with `tx_data` equal to bits 7:0 of the written word, and sets raw status bit 5 from the next cycle.
- R8: Word 14 is a 32-bit read/write mask. Word 15 reads the raw status, word 16 reads raw AND mask, and `irq` is high exactly when that masked value is non-zero.
- R9: Writing word 17 clears every raw status bit that is 1 in the written value. A receive set of bit 4 in the same cycle takes precedence over the clear.
- R10: Word offsets 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R11: Words 9, 10, 11, 12 and 13 store and read back the low 16, 6, 8, 16 and 6 bits of the written value. Any other unmapped offset reads 0 and ignores writes.
- R12: After reset the queue is empty, the flags read 0x90, and the raw status, the mask, all stored registers and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on word 0) |
| bus_addr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| rx_valid | input | 1 | Incoming byte is offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue has room; a byte is taken when valid and ready are both high |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that the bus never raises `bus_wr` and `bus_rd` in the same cycle. They also assume that reset is applied before the first strobe. The bench drives one register operation at a time, always from the falling edge and held for exactly one cycle. The only case where an incoming byte overlaps a bus access is a deliberate one, where a byte arrives together with a status-clear write to exercise the precedence rule. The random phase changes the threshold and the queue mode at arbitrary fill levels. This keeps thresholds above 16, a zero threshold and a queue shrunk below its fill within the assumed input space.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int OFS_DATA  = 0;
  localparam int OFS_FLAGS = 6;
  localparam int OFS_IDIV  = 9;
  localparam int OFS_FDIV  = 10;
  localparam int OFS_LINE  = 11;
  localparam int OFS_CTRL  = 12;
  localparam int OFS_LEVEL = 13;
  localparam int OFS_MASK  = 14;
  localparam int OFS_RAW   = 15;
  localparam int OFS_MIS   = 16;
  localparam int OFS_ICLR  = 17;

  localparam int RX_EVT_BIT = 4;
  localparam int TX_EVT_BIT = 5;
  localparam int LINE_QUEUE_ON = 4;

  // receive threshold derived from the level register and the queue mode
  function automatic logic [4:0] rx_threshold(input logic queue_on, input logic [5:0] level);
    return queue_on ? {level[5:3], 2'b00} : 5'd1;
  endfunction

  // fixed identification bytes, index 0 at the lowest of the top eight words
  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fill_next
);
  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] rd_pos;
  logic [AW-1:0] wr_slot;
  logic          pop_take;

  assign pop_take  = pop && (fill != '0);
  assign wr_slot   = rd_pos + fill[AW-1:0];
  assign fill_next = fill + CW'(push) - CW'(pop_take);
  assign head      = slots[rd_pos];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_slot == AW'(i))) slots[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos <= '0;
      fill   <= '0;
    end else begin
      fill <= fill_next;
      if (pop_take) rd_pos <= rd_pos + AW'(1);
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (fill == $past(fill) + CW'(1)));
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && fill == '0) |=> (fill == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_fe_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_set,
  input  logic              rx_drop,
  input  logic              tx_set,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] wval,
  output logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] mask,
  output logic              irq
);
  logic raw_rx, raw_tx;
  logic clr_rx, clr_tx;

  assign clr_rx = clr_wr && wval[RX_EVT_BIT];
  assign clr_tx = clr_wr && wval[TX_EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_rx <= 1'b0;
      raw_tx <= 1'b0;
      mask   <= '0;
    end else begin
      raw_rx <= rx_set || (raw_rx && !clr_rx && !rx_drop);
      raw_tx <= tx_set || (raw_tx && !clr_tx);
      if (mask_wr) mask <= wval;
    end
  end

  always_comb begin
    raw = '0;
    raw[RX_EVT_BIT] = raw_rx;
    raw[TX_EVT_BIT] = raw_tx;
  end

  assign irq = |(raw & mask);

  // R7
  tx_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> raw_tx);
  // R9
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !tx_set) |=> !raw_tx);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && clr_rx) |=> raw_rx);
endmodule

// File: rtl/uart_fe.sv
module uart_fe
  import uart_fe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AW_BUS = 10,
  parameter int WORD_W = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW_BUS-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic [15:0] idiv_r;
  logic [5:0]  fdiv_r;
  logic [7:0]  line_r;
  logic [15:0] ctrl_r;
  logic [5:0]  level_r;

  logic          queue_on;
  logic [CW-1:0] cap, thresh, fill, fill_next;
  logic [7:0]    head;
  logic          push, data_rd, id_hit;
  logic          rx_set, rx_drop;
  logic [WORD_W-1:0] raw, mask, flags;

  assign queue_on = line_r[LINE_QUEUE_ON];
  assign cap      = queue_on ? CW'(DEPTH) : CW'(1);
  assign thresh   = CW'(rx_threshold(queue_on, level_r));
  assign rx_ready = fill < cap;
  assign push     = rx_valid && rx_ready;
  assign data_rd  = bus_rd && !bus_wr && (bus_addr == AW_BUS'(OFS_DATA));
  assign id_hit   = &bus_addr[AW_BUS-1:3];

  // named events for the interrupt block
  assign rx_set  = push && (fill_next == thresh);
  assign rx_drop = data_rd && (fill_next == thresh - CW'(1));

  assign tx_valid = bus_wr && (bus_addr == AW_BUS'(OFS_DATA));
  assign tx_data  = bus_wdata[7:0];

  uart_rx_queue #(.DEPTH(DEPTH), .DW(8)) i_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(rx_data), .pop(data_rd),
    .head(head), .fill(fill), .fill_next(fill_next)
  );

  uart_irq_ctrl #(.WORD_W(WORD_W)) i_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_set(rx_set), .rx_drop(rx_drop), .tx_set(tx_valid),
    .clr_wr(bus_wr && (bus_addr == AW_BUS'(OFS_ICLR))),
    .mask_wr(bus_wr && (bus_addr == AW_BUS'(OFS_MASK))),
    .wval(bus_wdata), .raw(raw), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idiv_r  <= '0;
      fdiv_r  <= '0;
      line_r  <= '0;
      ctrl_r  <= '0;
      level_r <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW_BUS'(OFS_IDIV):  idiv_r  <= bus_wdata[15:0];
        AW_BUS'(OFS_FDIV):  fdiv_r  <= bus_wdata[5:0];
        AW_BUS'(OFS_LINE):  line_r  <= bus_wdata[7:0];
        AW_BUS'(OFS_CTRL):  ctrl_r  <= bus_wdata[15:0];
        AW_BUS'(OFS_LEVEL): level_r <= bus_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    flags = '0;
    flags[7] = 1'b1;
    flags[6] = fill >= cap;
    flags[5] = 1'b0;
    flags[4] = fill == '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (id_hit) begin
      bus_rdata = WORD_W'(ident_byte(bus_addr[2:0]));
    end else begin
      case (bus_addr)
        AW_BUS'(OFS_DATA):  bus_rdata = (fill == '0) ? '0 : WORD_W'(head);
        AW_BUS'(OFS_FLAGS): bus_rdata = flags;
        AW_BUS'(OFS_IDIV):  bus_rdata = WORD_W'(idiv_r);
        AW_BUS'(OFS_FDIV):  bus_rdata = WORD_W'(fdiv_r);
        AW_BUS'(OFS_LINE):  bus_rdata = WORD_W'(line_r);
        AW_BUS'(OFS_CTRL):  bus_rdata = WORD_W'(ctrl_r);
        AW_BUS'(OFS_LEVEL): bus_rdata = WORD_W'(level_r);
        AW_BUS'(OFS_MASK):  bus_rdata = mask;
        AW_BUS'(OFS_RAW):   bus_rdata = raw;
        AW_BUS'(OFS_MIS):   bus_rdata = raw & mask;
        default:            bus_rdata = '0;
      endcase
    end
  end

  // R2
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_on && fill != '0) |-> !rx_ready);
  // R6
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> !raw[RX_EVT_BIT]);
endmodule

// File: tb/test_uart_fe.sv
`timescale 1ns/1ps
module test_uart_fe;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 0, rx_ready, tx_valid, irq;
  logic [7:0] rx_data = '0, tx_data;

  int n_chk = 0, n_bad = 0;

  uart_fe i_uart_fe (.*);

  always #10 clk = ~clk;

  logic [7:0] q[$];
  logic [31:0] m_mask = 0;
  logic m_rx = 0, m_tx = 0;
  logic [7:0] m_line = 0;
  logic [5:0] m_level = 0;

  function automatic int f_cap();
    return m_line[4] ? 16 : 1;
  endfunction
  function automatic int f_trig();
    if (!m_line[4]) return 1;
    return (int'(m_level) / 8) * 4;
  endfunction
  function automatic logic [31:0] f_raw();
    return (m_rx ? 32'h10 : 0) + (m_tx ? 32'h20 : 0);
  endfunction
  function automatic logic [31:0] f_flags();
    return 32'h80 + ((q.size() >= f_cap()) ? 32'h40 : 0) + ((q.size() == 0) ? 32'h10 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #2;
    if (a == 0) begin
      check(tx_valid === 1'b1, "R7 tx_valid", 32'(tx_valid), 1);
      check(tx_data === d[7:0], "R7 tx_data", 32'(tx_data), 32'(d[7:0]));
    end
    @(negedge clk);
    bus_wr = 0;
    case (a)
      10'd0:  m_tx = 1;
      10'd11: m_line = d[7:0];
      10'd13: m_level = d[5:0];
      10'd14: m_mask = d;
      10'd17: begin if (d[4]) m_rx = 0; if (d[5]) m_tx = 0; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic pop_chk(input string req);
    logic [31:0] v, exp;
    exp = (q.size() > 0) ? 32'(q[0]) : 32'h0;
    rd(10'd0, v);
    check(v === exp, req, v, exp);
    if (q.size() > 0) void'(q.pop_front());
    if (q.size() == f_trig() - 1) m_rx = 0;
  endtask

  task automatic push(input logic [7:0] b, input string req);
    bit exp_rdy;
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    exp_rdy = q.size() < f_cap();
    #2 check(rx_ready === exp_rdy, req, 32'(rx_ready), 32'(exp_rdy));
    @(negedge clk);
    rx_valid = 0;
    if (exp_rdy) begin
      q.push_back(b);
      if (q.size() == f_trig()) m_rx = 1;
    end
  endtask

  task automatic status_chk(input string req);
    rd_chk(10'd6, f_flags(), {req, " R4 flags"});
    rd_chk(10'd15, f_raw(), {req, " R8 raw"});
    rd_chk(10'd16, f_raw() & m_mask, {req, " R8 masked"});
    #1 check(irq === ((f_raw() & m_mask) != 0), {req, " R8 irq"}, 32'(irq), 32'((f_raw() & m_mask) != 0));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] id_exp [8];
    void'($urandom(32'd20240607));
    id_exp = '{32'h11, 32'h10, 32'h14, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    rd_chk(10'd6, 32'h90, "R12 flags");
    rd_chk(10'd15, 32'h0, "R12 raw");
    rd_chk(10'd14, 32'h0, "R12 mask");
    rd_chk(10'd11, 32'h0, "R12 line");
    check(irq === 1'b0, "R12 irq", 32'(irq), 0);

    // R11 stored registers and unmapped space
    wr(10'd9, 32'hFFFF_ABCD);  rd_chk(10'd9, 32'hABCD, "R11 idiv");
    wr(10'd10, 32'hFF);        rd_chk(10'd10, 32'h3F, "R11 fdiv");
    wr(10'd12, 32'h12345);     rd_chk(10'd12, 32'h2345, "R11 ctrl");
    wr(10'd13, 32'h7F);        rd_chk(10'd13, 32'h3F, "R11 level");
    wr(10'd20, 32'hFFFF_FFFF); rd_chk(10'd20, 32'h0, "R11 unmapped");

    // R2 single slot with the queue off, R5/R6 threshold 1
    wr(10'd11, 32'h0);
    push(8'hA1, "R2 first accepted");
    push(8'hB2, "R2 second refused");
    status_chk("R2 R5 one held");
    pop_chk("R3 R2 single read");
    status_chk("R6 cleared at zero");
    pop_chk("R3 empty read");
    rd_chk(10'd6, 32'h90, "R3 R4 still empty");

    // R1 R5 R6 threshold 8 with the queue on
    wr(10'd13, 32'h10);
    wr(10'd11, 32'h10);
    wr(10'd14, 32'h10);
    for (int i = 0; i < 7; i++) push(8'(8'h40 + i), "R1 fill");
    status_chk("R5 below threshold");
    push(8'h47, "R1 fill");
    status_chk("R5 R8 at threshold");
    pop_chk("R3 R6 read below threshold");
    status_chk("R6 after read");
    for (int i = 0; i < 10; i++) push(8'(8'h60 + i), "R1 fill to top");
    status_chk("R1 R4 full");
    for (int i = 0; i < 17; i++) pop_chk("R1 R3 order");
    status_chk("R1 drained");

    // R7 transmit, R9 clear
    wr(10'd0, 32'h1A5);
    status_chk("R7 tx raised");
    wr(10'd17, 32'h20);
    status_chk("R9 tx cleared");

    // R9 receive set wins over same-cycle clear (threshold 4)
    wr(10'd13, 32'h08);
    for (int i = 0; i < 3; i++) push(8'(8'h70 + i), "R9 prefill");
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h73; bus_wr = 1; bus_addr = 10'd17; bus_wdata = 32'h10;
    @(negedge clk);
    rx_valid = 0; bus_wr = 0;
    q.push_back(8'h73); m_rx = 1;
    status_chk("R9 set beats clear");
    wr(10'd17, 32'h10);
    status_chk("R9 plain clear");
    while (q.size() > 0) pop_chk("R3 drain");

    // R10 identification bytes
    for (int i = 0; i < 8; i++) rd_chk(10'(10'h3F8 + i), id_exp[i], "R10 ident");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: push(8'($urandom), "R1 R2 random push");
        3, 4:    pop_chk("R3 R6 random read");
        5:       wr(10'd0, $urandom);
        6:       wr(10'd17, $urandom);
        7:       wr(10'd14, $urandom);
        8:       begin
                   wr(10'd13, $urandom);
                   wr(10'd11, ($urandom_range(0, 3) == 0) ? 32'h0 : 32'h10);
                 end
        default: status_chk("R5 R8 random status");
      endcase
    end
    status_chk("final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule